// File: doc/BRIEF.md
# 100BASE-TX Receive Framer

This block sits just after the descrambler in a 100BASE-TX receive path. It takes one descrambled code bit per cycle when `bit_vld_i` is high. While the line is idle it watches for activity, finds the start-of-stream delimiter, and uses it to lock the 5-bit code-group boundary. It then decodes 4B/5B data groups into nibbles. The results come out as MII-style receive levels (`rx_dv_o`, `rx_er_o`, `rxd_o`) together with a one-cycle nibble strobe.

The framer also handles the abnormal cases. Activity that is not a valid delimiter becomes a false-carrier report, and the block then stays deaf until the line has been quiet for a set run of ones. Inside a frame, it reports a bad code group, a premature pair of idle groups, a malformed end delimiter, or a loss of descrambler sync as a receive error. Each nibble is presented one code group after the group that carries it. This lag lets the delimiter pair appear as two preamble nibbles.

Top module: `fx_rx_framer`

## Requirements
- R1: After reset, whether applied at start or during a frame, `nib_stb_o`, `rx_dv_o`, `rx_er_o` and `rxd_o` are all 0, and the next delimiter is found from the idle state.
- R2: The bit sequence 11000 then 10001 (J then K, first bit first), arriving after idle ones, produces a strobe with dv=1, er=0, rxd=0101. The following group produces a second 0101 strobe.
- R3: In a frame, a strobe occurs once every 5 valid bits. Each data group decodes by the table 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. Its nibble is presented (dv=1, er=0) at the strobe of the next group.
- R4: A T group (01101) presents the last data nibble. A following R group (00111) gives a closing strobe with dv=0, er=0, rxd=0000, and the block returns to idle.
- R5: When the 10-bit window ending 7 bits after the first zero is not J/K and holds two non-adjacent zeros, a strobe with dv=0, er=1, rxd=1110 is issued. The same strobe repeats every 5 valid bits while the condition lasts.
- R6: After a false carrier, all bits are ignored, including J/K patterns, until 10 consecutive ones arrive. On the tenth one a closing strobe of zeros is issued and delimiter search resumes.
- R7: In a frame, a group that is neither data, T nor idle is reported one group later as dv=1, er=1, rxd=0110, and the frame continues.
- R8: Two consecutive idle groups (11111) in a frame present the held nibble at the first idle and dv=1, er=1, rxd=0110 at the second. The next group gives a closing strobe of zeros.
- R9: `sync_lost_i` high during a frame makes the strobe at the end of the current group dv=1, er=1, rxd=0110. The next group gives a closing strobe of zeros.
- R10: Cycles with `bit_vld_i` low neither advance the framer nor strobe, whatever the value on `bit_i`.
- R11: A lone zero, or two adjacent zeros, followed by ones returns the block to idle with no strobe.
- R12: A T group followed by anything but R gives dv=1, er=1, rxd=0110, then a closing strobe of zeros one group later.
- R13: `rx_dv_o`, `rx_er_o` and `rxd_o` change only in cycles where `nib_stb_o` is high, or by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Descrambled code bit |
| bit_vld_i | input | 1 | `bit_i` carries a valid bit this cycle |
| sync_lost_i | input | 1 | Descrambler has lost synchronisation |
| nib_stb_o | output | 1 | One-cycle strobe: receive levels are updated |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error / false carrier |
| rxd_o | output | 4 | Receive nibble |

## Verification
The hardest state to reach from the ports is the false-carrier hold. To get there, the window check must fire on a non-delimiter pattern. After that, traffic that would otherwise frame must still be ignored, and the exit must fall exactly on the tenth consecutive one. The bench drives a pattern with zeros three bits apart. It then sends a complete J/K pair and a stray zero while the block is deaf, followed by exactly ten ones. This pins both the repeating 1110 strobes and the closing strobe to known bit positions, and a clean frame afterwards confirms that search has resumed. Frames containing invalid groups, doubled idles, a broken T/R pair, and a one-cycle sync-loss pulse each reach their error path with a known strobe sequence.

// File: rtl/fx_rx_pkg.sv
package fx_rx_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_TC   = 5'b01101;
  localparam logic [CG_W-1:0] CG_RC   = 5'b00111;
  localparam logic [CG_W-1:0] CG_IDLC = 5'b11111;

  localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_FC  = 4'b1110;
  localparam logic [NIB_W-1:0] NIB_ERR = 4'b0110;

  typedef enum logic [2:0] {CG_DATA, CG_IDLE, CG_T, CG_R, CG_BAD} cg_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_SEARCH, ST_FRAME, ST_FCAR, ST_CLOSE} rx_st_e;
endpackage

// File: rtl/fx_rx_window.sv
module fx_rx_window
  import fx_rx_pkg::*;
#(
  parameter int GW = CG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_i,
  input  logic          bit_vld_i,
  output logic [GW-1:0] grp_o,
  output logic          jk_o,
  output logic          split_o
);
  localparam int WIN_W   = 2 * GW;
  localparam int FAR_TOP = WIN_W - 5; // first zero sits at WIN_W-3 on evaluation

  logic [WIN_W-1:0] sh_q;
  logic [WIN_W-1:0] win;

  assign win = {sh_q[WIN_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '1;
    else if (bit_vld_i) sh_q <= win;
  end

  assign grp_o   = win[GW-1:0];
  assign jk_o    = (win == {CG_J, CG_K});
  assign split_o = |(~win[FAR_TOP:0]);
endmodule

// File: rtl/fx_rx_group_dec.sv
module fx_rx_group_dec
  import fx_rx_pkg::*;
(
  input  logic [CG_W-1:0]  grp_i,
  output cg_kind_e         kind_o,
  output logic [NIB_W-1:0] nib_o
);
  always_comb begin
    kind_o = CG_DATA;
    nib_o  = '0;
    case (grp_i)
      5'b11110: nib_o = 4'h0;
      5'b01001: nib_o = 4'h1;
      5'b10100: nib_o = 4'h2;
      5'b10101: nib_o = 4'h3;
      5'b01010: nib_o = 4'h4;
      5'b01011: nib_o = 4'h5;
      5'b01110: nib_o = 4'h6;
      5'b01111: nib_o = 4'h7;
      5'b10010: nib_o = 4'h8;
      5'b10011: nib_o = 4'h9;
      5'b10110: nib_o = 4'hA;
      5'b10111: nib_o = 4'hB;
      5'b11010: nib_o = 4'hC;
      5'b11011: nib_o = 4'hD;
      5'b11100: nib_o = 4'hE;
      5'b11101: nib_o = 4'hF;
      CG_IDLC:  kind_o = CG_IDLE;
      CG_TC:    kind_o = CG_T;
      CG_RC:    kind_o = CG_R;
      default:  kind_o = CG_BAD;
    endcase
  end
endmodule

// File: rtl/fx_rx_framer.sv
module fx_rx_framer
  import fx_rx_pkg::*;
#(
  parameter int QUIET_RUN = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             sync_lost_i,
  output logic             nib_stb_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic [NIB_W-1:0] rxd_o
);
  localparam int WIN_W       = 2 * CG_W;
  localparam int SEARCH_BITS = WIN_W - 3;
  localparam int CNT_W       = $clog2(SEARCH_BITS);
  localparam int ONES_W      = $clog2(QUIET_RUN + 1);
  localparam logic [CNT_W-1:0]  SEARCH_LAST = CNT_W'(SEARCH_BITS - 1);
  localparam logic [CNT_W-1:0]  GRP_LAST    = CNT_W'(CG_W - 1);
  localparam logic [ONES_W-1:0] RUN_LAST    = ONES_W'(QUIET_RUN - 1);

  logic [CG_W-1:0]  grp;
  logic             jk, split;
  cg_kind_e         kind;
  logic [NIB_W-1:0] dec_nib;

  fx_rx_window #(.GW(CG_W)) u_window (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i,
    .grp_o(grp), .jk_o(jk), .split_o(split)
  );

  fx_rx_group_dec u_dec (.grp_i(grp), .kind_o(kind), .nib_o(dec_nib));

  rx_st_e            st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic [NIB_W-1:0]  hold_nib_q, hold_nib_d;
  logic              hold_er_q, hold_er_d;
  logic              idle1_q, idle1_d, t_seen_q, t_seen_d, sl_q, sl_d;
  logic              stb_d, dv_d, er_d;
  logic [NIB_W-1:0]  rxd_d;
  logic              grp_end;

  assign grp_end = (cnt_q == GRP_LAST);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; ones_d = ones_q;
    hold_nib_d = hold_nib_q; hold_er_d = hold_er_q;
    idle1_d = idle1_q; t_seen_d = t_seen_q;
    sl_d  = sl_q | (sync_lost_i && st_q == ST_FRAME);
    stb_d = 1'b0; dv_d = rx_dv_o; er_d = rx_er_o; rxd_d = rxd_o;
    if (bit_vld_i) begin
      case (st_q)
        ST_IDLE: if (!bit_i) begin st_d = ST_SEARCH; cnt_d = '0; end
        ST_SEARCH: begin
          if (cnt_q == SEARCH_LAST) begin
            cnt_d = '0;
            if (jk) begin
              st_d = ST_FRAME; stb_d = 1'b1; dv_d = 1'b1; er_d = 1'b0; rxd_d = NIB_PRE;
              hold_nib_d = NIB_PRE; hold_er_d = 1'b0;
              idle1_d = 1'b0; t_seen_d = 1'b0; sl_d = 1'b0;
            end else if (split) begin
              st_d = ST_FCAR; stb_d = 1'b1; dv_d = 1'b0; er_d = 1'b1; rxd_d = NIB_FC;
              ones_d = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_FRAME: begin
          cnt_d = grp_end ? '0 : cnt_q + 1'b1;
          if (grp_end) begin
            sl_d = 1'b0;
            if (sl_q || sync_lost_i) begin
              st_d = ST_CLOSE; stb_d = 1'b1; dv_d = 1'b1; er_d = 1'b1; rxd_d = NIB_ERR;
            end else if (t_seen_q) begin
              stb_d = 1'b1;
              if (kind == CG_R) begin
                st_d = ST_IDLE; dv_d = 1'b0; er_d = 1'b0; rxd_d = '0;
              end else begin
                st_d = ST_CLOSE; dv_d = 1'b1; er_d = 1'b1; rxd_d = NIB_ERR;
              end
            end else begin
              // output lags one group: present the held nibble
              stb_d = 1'b1; dv_d = 1'b1; er_d = hold_er_q; rxd_d = hold_nib_q;
              case (kind)
                CG_DATA: begin hold_nib_d = dec_nib; hold_er_d = 1'b0; idle1_d = 1'b0; end
                CG_T:    t_seen_d = 1'b1;
                CG_IDLE: begin
                  if (idle1_q) st_d = ST_CLOSE;
                  idle1_d = 1'b1; hold_nib_d = NIB_ERR; hold_er_d = 1'b1;
                end
                default: begin hold_nib_d = NIB_ERR; hold_er_d = 1'b1; idle1_d = 1'b0; end
              endcase
            end
          end
        end
        ST_FCAR: begin
          cnt_d  = grp_end ? '0 : cnt_q + 1'b1;
          ones_d = bit_i ? ones_q + 1'b1 : '0;
          if (bit_i && ones_q == RUN_LAST) begin
            st_d = ST_IDLE; stb_d = 1'b1; dv_d = 1'b0; er_d = 1'b0; rxd_d = '0;
          end else if (grp_end) begin
            stb_d = 1'b1; dv_d = 1'b0; er_d = 1'b1; rxd_d = NIB_FC;
          end
        end
        ST_CLOSE: begin
          cnt_d = grp_end ? '0 : cnt_q + 1'b1;
          if (grp_end) begin
            st_d = ST_IDLE; stb_d = 1'b1; dv_d = 1'b0; er_d = 1'b0; rxd_d = '0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; ones_q <= '0;
      hold_nib_q <= '0; hold_er_q <= 1'b0;
      idle1_q <= 1'b0; t_seen_q <= 1'b0; sl_q <= 1'b0;
      nib_stb_o <= 1'b0; rx_dv_o <= 1'b0; rx_er_o <= 1'b0; rxd_o <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; ones_q <= ones_d;
      hold_nib_q <= hold_nib_d; hold_er_q <= hold_er_d;
      idle1_q <= idle1_d; t_seen_q <= t_seen_d; sl_q <= sl_d;
      nib_stb_o <= stb_d; rx_dv_o <= dv_d; rx_er_o <= er_d; rxd_o <= rxd_d;
    end
  end

  assert_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nib_stb_o |-> ($stable(rx_dv_o) && $stable(rx_er_o) && $stable(rxd_o)));

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !nib_stb_o);

  assert_fc_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_er_o && !rx_dv_o) |-> (rxd_o == NIB_FC));

  assert_err_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_er_o && rx_dv_o) |-> (rxd_o == NIB_ERR));

  assert_sof_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dv_o) |-> (rxd_o == NIB_PRE && !rx_er_o));
endmodule

// File: tb/fx_rx_framer_bench.sv
module fx_rx_framer_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, bit_in, vld, sl;
  logic       stb, dv, er;
  logic [3:0] rxd;

  fx_rx_framer u_fx_rx_framer (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_vld_i(vld),
    .sync_lost_i(sl), .nib_stb_o(stb), .rx_dv_o(dv), .rx_er_o(er), .rxd_o(rxd)
  );

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101, R = 5'b00111;
  localparam logic [4:0] IDL = 5'b11111;
  localparam logic [8:0] CODE_TAB [16] = '{
    {4'h0, 5'b11110}, {4'h1, 5'b01001}, {4'h2, 5'b10100}, {4'h3, 5'b10101},
    {4'h4, 5'b01010}, {4'h5, 5'b01011}, {4'h6, 5'b01110}, {4'h7, 5'b01111},
    {4'h8, 5'b10010}, {4'h9, 5'b10011}, {4'hA, 5'b10110}, {4'hB, 5'b10111},
    {4'hC, 5'b11010}, {4'hD, 5'b11011}, {4'hE, 5'b11100}, {4'hF, 5'b11101}};

  int checks = 0, errors = 0, vcount = 0, gap_stb = 0, hold_bad = 0;
  int log_n = 0, exp_n = 0;
  logic [5:0] log_e [64];
  int         log_p [64];
  logic [5:0] exp_e [64];
  logic [5:0] last_out = '0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic v, input logic s);
    @(negedge clk); bit_in = b; vld = v; sl = s;
    @(posedge clk); #1;
    if (v) vcount++;
    if (stb) begin
      if (!v) gap_stb++;
      if (log_n < 64) begin log_e[log_n] = {dv, er, rxd}; log_p[log_n] = vcount; log_n++; end
      last_out = {dv, er, rxd};
    end else if ({dv, er, rxd} != last_out) hold_bad++;
  endtask

  task automatic send_cg(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) step(c[i], 1'b1, 1'b0);
  endtask

  task automatic send_cg_gap(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) begin step(c[i], 1'b1, 1'b0); step(1'b0, 1'b0, 1'b0); end
  endtask

  task automatic send_ones(input int n);
    repeat (n) step(1'b1, 1'b1, 1'b0);
  endtask

  task automatic expect_out(input logic d, input logic e, input logic [3:0] n);
    exp_e[exp_n] = {d, e, n}; exp_n++;
  endtask

  task automatic compare_log(input string req);
    chk({req, " strobe count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) chk({req, " strobe value"}, int'(log_e[i]), int'(exp_e[i]));
    log_n = 0; exp_n = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; vld = 1'b0; bit_in = 1'b1; sl = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk("R1 outputs in reset", int'({stb, dv, er, rxd}), 0);
    @(negedge clk); rst_n = 1'b1;
    last_out = '0; log_n = 0; exp_n = 0;
  endtask

  task automatic good_frame(input logic [4:0] code, input logic [3:0] nib);
    send_ones(8); send_cg(J); send_cg(K); send_cg(code); send_cg(T); send_cg(R); send_ones(6);
    expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'b0101); expect_out(1, 0, nib); expect_out(0, 0, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vld = 1'b0; bit_in = 1'b1; sl = 1'b0;
    do_reset();

    // R2 R3 R4: one frame per table entry
    for (int i = 0; i < 16; i++) begin
      good_frame(CODE_TAB[i][4:0], CODE_TAB[i][8:5]);
      compare_log("R3 decode / R2 preamble / R4 end");
    end

    // R10 R3: gapped bits with garbage on invalid cycles, spacing check
    send_ones(8);
    send_cg_gap(J); send_cg_gap(K); send_cg_gap(CODE_TAB[5][4:0]);
    send_cg_gap(CODE_TAB[10][4:0]); send_cg_gap(CODE_TAB[3][4:0]);
    send_cg_gap(T); send_cg_gap(R); send_ones(6);
    for (int i = 1; i < log_n; i++) chk("R3 strobe spacing", log_p[i] - log_p[i-1], 5);
    expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'h5);
    expect_out(1, 0, 4'hA); expect_out(1, 0, 4'h3); expect_out(0, 0, 4'h0);
    compare_log("R10 gapped frame");

    // R5 R6: false carrier, J/K ignored, exit on tenth one
    send_ones(8);
    step(0, 1, 0); step(1, 1, 0); step(0, 1, 0);
    repeat (5) step(1, 1, 0);
    chk("R5 false carrier strobe position", log_n, 1);
    send_cg(J); send_cg(K); step(0, 1, 0);
    send_ones(9);
    chk("R6 still deaf before tenth one", log_n, 5);
    send_ones(1);
    for (int i = 0; i < 5; i++) expect_out(0, 1, 4'b1110);
    expect_out(0, 0, 4'h0);
    compare_log("R5 false carrier / R6 recovery");
    good_frame(CODE_TAB[7][4:0], 4'h7);
    compare_log("R6 frame after recovery");

    // R11: lone zero and adjacent zeros
    send_ones(8); step(0, 1, 0); send_ones(12);
    step(0, 1, 0); step(0, 1, 0); send_ones(12);
    compare_log("R11 noise ignored");
    good_frame(CODE_TAB[2][4:0], 4'h2);
    compare_log("R11 frame after noise");

    // R7: invalid group in frame
    send_ones(8); send_cg(J); send_cg(K); send_cg(CODE_TAB[1][4:0]); send_cg(J);
    send_cg(CODE_TAB[2][4:0]); send_cg(T); send_cg(R); send_ones(6);
    expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'h1);
    expect_out(1, 1, 4'b0110); expect_out(1, 0, 4'h2); expect_out(0, 0, 4'h0);
    compare_log("R7 invalid group");

    // R8: premature idle pair
    send_ones(8); send_cg(J); send_cg(K); send_cg(CODE_TAB[9][4:0]);
    send_cg(IDL); send_cg(IDL); send_ones(10);
    expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'h9);
    expect_out(1, 1, 4'b0110); expect_out(0, 0, 4'h0);
    compare_log("R8 premature idle");

    // R9: sync loss pulse mid group
    send_ones(8); send_cg(J); send_cg(K); send_cg(CODE_TAB[4][4:0]);
    step(0, 1, 0); step(1, 1, 1); step(0, 1, 0); step(1, 1, 0); step(1, 1, 0);
    send_ones(10);
    expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'b0101);
    expect_out(1, 1, 4'b0110); expect_out(0, 0, 4'h0);
    compare_log("R9 sync loss");

    // R12: T not followed by R
    send_ones(8); send_cg(J); send_cg(K); send_cg(CODE_TAB[12][4:0]);
    send_cg(T); send_cg(CODE_TAB[0][4:0]); send_ones(10);
    expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'b0101); expect_out(1, 0, 4'hC);
    expect_out(1, 1, 4'b0110); expect_out(0, 0, 4'h0);
    compare_log("R12 broken end delimiter");

    // R1: reset during a frame
    send_ones(8); send_cg(J); send_cg(K); step(1, 1, 0); step(0, 1, 0);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 outputs on mid-frame reset", int'({stb, dv, er, rxd}), 0);
    do_reset();
    good_frame(CODE_TAB[8][4:0], 4'h8);
    compare_log("R1 frame after reset");

    chk("R10 strobe on invalid cycle", gap_stb, 0);
    chk("R13 outputs held between strobes", hold_bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule